// File: doc/BRIEF.md
# Asynchronous Serial Character Engine

This block sends and receives asynchronous serial characters one at a time. Each direction runs from its own single-cycle sample tick, which comes at sixteen times the bit rate. On the send side a byte is written into a one-entry holding register. At the next send tick while the line is idle, the byte moves into the shift stage. It then leaves on the serial output as a start bit, the data bits least significant first, an optional parity bit and a stop period.

The receive side synchronises the serial input and looks for a falling edge. It confirms the start bit half a bit later, then samples every following bit at its centre tick. It delivers the byte with a ready flag and per-character error flags.

One set of line-setting inputs applies to both directions: character length, parity enable and sense, and the long-stop option. A level input can force a break onto the output. A received all-zero character is reported as a break. The divider that makes the ticks and the register access around the block live elsewhere.

Top module: `uart_char_engine`

## Requirements
- R1: During and after reset `sout` is high, `tx_hold_empty` and `tx_shift_empty` are 1, and `rx_rdy`, `ovr_err`, `par_err`, `frm_err`, `brk_det` are 0.
- R2: A sent character is a low start bit, then the data bits LSB first, then the stop period. Each bit lasts OVERSAMPLE send ticks, and the number of data bits is 5 plus `len_sel` (0..3 gives 5..8).
- R3: With `par_en`=1, a parity bit follows the data. With `par_even`=1 it makes the count of ones over data plus parity even, and with `par_even`=0 it makes that count odd. With `par_en`=0 no parity bit is sent.
- R4: The stop period is one bit time when `stop_long`=0. When `stop_long`=1 it is 1.5 bit times for 5-bit characters and 2 bit times for any other length.
- R5: A write sets `tx_hold_empty` to 0, and a write while it is 0 is ignored. At the first send tick with the shift stage idle, the byte moves into the shift stage and `tx_hold_empty` returns to 1. `tx_shift_empty` is 0 from that tick until the last stop tick has passed.
- R6: While `brk_force` is 1, `sout` is 0. The send timing continues unchanged underneath.
- R7: The receiver takes each bit at tick 8 of its 16, counted from the tick that saw the start edge. It presents the data bits in `rx_data` with the unsent high bits at 0, and sets `rx_rdy` when the stop bit is taken.
- R8: A low level that is high again at the start bit's centre sample is dropped without setting any flag.
- R9: `par_err` is set when parity is enabled and the received parity bit does not match the setting.
- R10: `frm_err` is set when the stop bit is sampled low.
- R11: `brk_det` is set when data, parity and stop are all sampled low. After any low stop bit the receiver does not look for a new start until the input has been high.
- R12: If a character completes while `rx_rdy` is still 1, `ovr_err` is set and the new character replaces the old one.
- R13: A one-cycle `rx_rd` pulse clears `rx_rdy` and all four error flags. An error flag is never 1 while `rx_rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous master reset, active high |
| tx_tick | input | 1 | Send-side 16x sample tick, one cycle wide |
| rx_tick | input | 1 | Receive-side 16x sample tick, one cycle wide |
| len_sel | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 for even parity, 0 for odd |
| stop_long | input | 1 | Long stop period |
| brk_force | input | 1 | Hold the serial output low |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 8 | Byte to send |
| tx_hold_empty | output | 1 | Holding register can take a byte |
| tx_shift_empty | output | 1 | No character is being shifted out |
| sout | output | 1 | Serial output |
| sin | input | 1 | Serial input, asynchronous |
| rx_rd | input | 1 | Acknowledge of the received character |
| rx_data | output | 8 | Received data |
| rx_rdy | output | 1 | A received character is waiting |
| ovr_err | output | 1 | A character was overwritten unread |
| par_err | output | 1 | Parity mismatch |
| frm_err | output | 1 | Stop bit sampled low |
| brk_det | output | 1 | All-zero character received |

## Verification
The properties take for granted that both ticks are single-cycle pulses spaced more clock cycles apart than the input synchroniser is deep. They also assume that all control inputs other than `sin` are synchronous to `clk`, and that the line settings do not change while a character is in flight. The bench keeps to this. It pulses each tick every fourth cycle, on different phases for the two directions. It changes the line settings only when both directions are idle. It holds every received bit for exactly sixteen receive ticks. It never pulses `rx_rd` in the cycle where a character completes.

// File: rtl/uce_pkg.sv
package uce_pkg;

   typedef enum logic [1:0] {LEN5 = 2'd0, LEN6 = 2'd1, LEN7 = 2'd2, LEN8 = 2'd3} char_len_e;

   typedef struct packed {
      logic [1:0] len;
      logic       par_en;
      logic       par_even;
      logic       stop_long;
   } line_cfg_t;

   // data bits in a character for a given length code
   function automatic logic [3:0] data_bits(logic [1:0] len);
      return 4'd5 + {2'b00, len};
   endfunction

   function automatic logic [7:0] len_mask(logic [1:0] len);
      return 8'hFF >> (2'd3 - len);
   endfunction

   // parity bit that completes the chosen sense over the live data bits
   function automatic logic par_bit(logic [7:0] d, logic [1:0] len, logic even);
      return (^(d & len_mask(len))) ^ ~even;
   endfunction

endpackage

// File: rtl/uce_tx.sv
module uce_tx
   import uce_pkg::*;
#(
   parameter int OS = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  line_cfg_t  cfg,
   input  logic       brk,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic       hold_empty,
   output logic       shift_empty,
   output logic       sout
);
   localparam int OS_LG  = $clog2(OS);
   localparam int TCNT_W = $clog2(12 * OS + 1);
   localparam int BIDX_W = TCNT_W - OS_LG;
   localparam int FW     = 2 ** BIDX_W;

   logic [7:0]        thr;
   logic              thr_full;
   logic              busy;
   logic [TCNT_W-1:0] tcnt, tlast, nxt_last;
   logic [FW-1:0]     frame, nxt_frame;
   logic [BIDX_W-1:0] bidx;

   // frame image: start at bit 0, data, optional parity, ones above
   always_comb begin
      nxt_frame    = '1;
      nxt_frame[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (i < int'(data_bits(cfg.len))) nxt_frame[i+1] = thr[i];
      if (cfg.par_en)
         nxt_frame[int'(data_bits(cfg.len)) + 1] = par_bit(thr, cfg.len, cfg.par_even);
   end

   always_comb begin
      int stop_t;
      int bits;
      bits = 1 + int'(data_bits(cfg.len)) + int'(cfg.par_en);
      if (!cfg.stop_long)          stop_t = OS;
      else if (cfg.len == LEN5)    stop_t = OS + OS / 2;
      else                         stop_t = 2 * OS;
      nxt_last = TCNT_W'(bits * OS + stop_t - 1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         thr      <= '0;
         thr_full <= 1'b0;
         busy     <= 1'b0;
         tcnt     <= '0;
         tlast    <= '0;
         frame    <= '1;
      end else begin
         if (wr && !thr_full) begin
            thr      <= wdata;
            thr_full <= 1'b1;
         end
         if (tick) begin
            if (busy) begin
               if (tcnt == tlast) busy <= 1'b0;
               else               tcnt <= tcnt + 1'b1;
            end else if (thr_full) begin
               busy     <= 1'b1;
               tcnt     <= '0;
               tlast    <= nxt_last;
               frame    <= nxt_frame;
               thr_full <= 1'b0;
            end
         end
      end
   end

   assign bidx        = tcnt[TCNT_W-1:OS_LG];
   assign hold_empty  = !thr_full;
   assign shift_empty = !busy;
   assign sout        = brk ? 1'b0 : (busy ? frame[bidx] : 1'b1);

endmodule

// File: rtl/uce_rx.sv
module uce_rx
   import uce_pkg::*;
#(
   parameter int OS   = 16,
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       sin,
   input  logic [1:0] len,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       rd,
   output logic [7:0] data,
   output logic       rdy,
   output logic       ovr,
   output logic       perr,
   output logic       ferr,
   output logic       brk
);
   localparam int OS_LG = $clog2(OS);
   localparam logic [OS_LG-1:0] HALF = OS_LG'(OS / 2);

   typedef enum logic [1:0] {RX_IDLE, RX_BUSY, RX_HOLD} rx_st_e;

   logic [SYNC-1:0]  sync_q;
   logic             line;
   rx_st_e           st;
   logic [OS_LG-1:0] cnt;
   logic [3:0]       bidx, nd;
   logic [7:0]       sh;
   logic             par_q;

   generate
      if (SYNC == 1) begin : g_sync_one
         always_ff @(posedge clk) sync_q <= rst ? 1'b1 : sin;
      end else begin : g_sync_chain
         always_ff @(posedge clk)
            sync_q <= rst ? '1 : {sync_q[SYNC-2:0], sin};
      end
   endgenerate

   assign line = sync_q[SYNC-1];
   assign nd   = data_bits(len);

   always_ff @(posedge clk) begin
      if (rst) begin
         st    <= RX_IDLE;
         cnt   <= '0;
         bidx  <= '0;
         sh    <= '0;
         par_q <= 1'b0;
         data  <= '0;
         rdy   <= 1'b0;
         ovr   <= 1'b0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
         brk   <= 1'b0;
      end else begin
         if (rd) begin
            rdy  <= 1'b0;
            ovr  <= 1'b0;
            perr <= 1'b0;
            ferr <= 1'b0;
            brk  <= 1'b0;
         end
         if (tick) begin
            unique case (st)
               RX_IDLE: if (!line) begin
                  st   <= RX_BUSY;
                  cnt  <= OS_LG'(1);
                  bidx <= '0;
                  sh   <= '0;
               end
               RX_BUSY: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == HALF) begin
                     if (bidx == 4'd0) begin
                        if (line) st <= RX_IDLE;   // start not confirmed
                        else      bidx <= 4'd1;
                     end else if (bidx <= nd) begin
                        sh[bidx[2:0] - 3'd1] <= line;
                        bidx <= bidx + 4'd1;
                     end else if (par_en && bidx == nd + 4'd1) begin
                        par_q <= line;
                        bidx  <= bidx + 4'd1;
                     end else begin
                        data <= sh;
                        rdy  <= 1'b1;
                        ovr  <= ovr | rdy;
                        perr <= par_en && (par_q != par_bit(sh, len, par_even));
                        ferr <= !line;
                        brk  <= !line && (sh == 8'd0) && (!par_en || !par_q);
                        st   <= line ? RX_IDLE : RX_HOLD;
                     end
                  end
               end
               RX_HOLD: if (line) st <= RX_IDLE;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_char_engine.sv
module uart_char_engine
   import uce_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tx_tick,
   input  logic       rx_tick,
   input  logic [1:0] len_sel,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       stop_long,
   input  logic       brk_force,
   input  logic       tx_wr,
   input  logic [7:0] tx_data,
   output logic       tx_hold_empty,
   output logic       tx_shift_empty,
   output logic       sout,
   input  logic       sin,
   input  logic       rx_rd,
   output logic [7:0] rx_data,
   output logic       rx_rdy,
   output logic       ovr_err,
   output logic       par_err,
   output logic       frm_err,
   output logic       brk_det
);
   if (OVERSAMPLE < 4 || (OVERSAMPLE & (OVERSAMPLE - 1)) != 0) begin : g_bad_os
      $error("OVERSAMPLE must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   line_cfg_t cfg;
   assign cfg = '{len: len_sel, par_en: par_en, par_even: par_even, stop_long: stop_long};

   uce_tx #(.OS(OVERSAMPLE)) u_tx (
      .clk         (clk),
      .rst         (rst),
      .tick        (tx_tick),
      .cfg         (cfg),
      .brk         (brk_force),
      .wr          (tx_wr),
      .wdata       (tx_data),
      .hold_empty  (tx_hold_empty),
      .shift_empty (tx_shift_empty),
      .sout        (sout)
   );

   uce_rx #(.OS(OVERSAMPLE), .SYNC(SYNC_STAGES)) u_rx (
      .clk      (clk),
      .rst      (rst),
      .tick     (rx_tick),
      .sin      (sin),
      .len      (len_sel),
      .par_en   (par_en),
      .par_even (par_even),
      .rd       (rx_rd),
      .data     (rx_data),
      .rdy      (rx_rdy),
      .ovr      (ovr_err),
      .perr     (par_err),
      .ferr     (frm_err),
      .brk      (brk_det)
   );

endmodule

// File: rtl/uce_checker.sv
module uce_checker (
   input logic clk,
   input logic rst,
   input logic brk_force,
   input logic sout,
   input logic tx_hold_empty,
   input logic tx_shift_empty,
   input logic rx_rdy,
   input logic ovr_err,
   input logic par_err,
   input logic frm_err,
   input logic brk_det
);
   p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
      (tx_shift_empty && !brk_force) |-> sout);

   p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
      ($fell(tx_shift_empty) && !brk_force) |-> !sout);

   p_load_frees_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(tx_shift_empty) |-> tx_hold_empty);

   p_break_low_r6: assert property (@(posedge clk) disable iff (rst)
      brk_force |-> !sout);

   p_break_frames_r11: assert property (@(posedge clk) disable iff (rst)
      brk_det |-> frm_err);

   p_ovr_prior_r12: assert property (@(posedge clk) disable iff (rst)
      $rose(ovr_err) |-> $past(rx_rdy));

   p_flags_need_rdy_r13: assert property (@(posedge clk) disable iff (rst)
      (ovr_err || par_err || frm_err || brk_det) |-> rx_rdy);
endmodule

bind uart_char_engine uce_checker u_chk (
   .clk            (clk),
   .rst            (rst),
   .brk_force      (brk_force),
   .sout           (sout),
   .tx_hold_empty  (tx_hold_empty),
   .tx_shift_empty (tx_shift_empty),
   .rx_rdy         (rx_rdy),
   .ovr_err        (ovr_err),
   .par_err        (par_err),
   .frm_err        (frm_err),
   .brk_det        (brk_det)
);

// File: tb/uart_char_engine_tb_top.sv
module uart_char_engine_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tx_tick = 1'b0, rx_tick = 1'b0;
   logic [1:0] len_sel = 2'd3;
   logic par_en = 1'b0, par_even = 1'b0, stop_long = 1'b0, brk_force = 1'b0;
   logic tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic sin = 1'b1, rx_rd = 1'b0;
   logic tx_hold_empty, tx_shift_empty, sout;
   logic [7:0] rx_data;
   logic rx_rdy, ovr_err, par_err, frm_err, brk_det;

   int n_vec = 0, n_bad = 0, cyc = 0;
   string req = "R1";
   bit done = 0;

   always #10 clk = ~clk;

   uart_char_engine dut_i (
      .clk(clk), .rst(rst), .tx_tick(tx_tick), .rx_tick(rx_tick),
      .len_sel(len_sel), .par_en(par_en), .par_even(par_even), .stop_long(stop_long),
      .brk_force(brk_force), .tx_wr(tx_wr), .tx_data(tx_data),
      .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty), .sout(sout),
      .sin(sin), .rx_rd(rx_rd), .rx_data(rx_data), .rx_rdy(rx_rdy),
      .ovr_err(ovr_err), .par_err(par_err), .frm_err(frm_err), .brk_det(brk_det)
   );

   // tick pulses: send side on phase 0, receive side on phase 2, every 4 cycles
   always @(negedge clk) begin
      cyc++;
      tx_tick = (cyc % 4 == 0);
      rx_tick = (cyc % 4 == 2);
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit ref_par(logic [7:0] d, int nd, bit even);
      int ones = 0;
      for (int i = 0; i < nd; i++) ones += d[i];
      return even ? bit'(ones % 2) : bit'(1 - ones % 2);
   endfunction

   // ---------------- send-side reference model ----------------
   bit m_full = 0, m_busy = 0, m_pe = 0, m_pv = 0;
   logic [7:0] m_hold = 0, m_byte = 0;
   int m_t = 0, m_ticks = 0, m_nd = 8;

   always @(posedge clk) begin
      if (rst) begin
         m_full = 0; m_busy = 0; m_t = 0;
      end else begin
         bit wr_ok, ld;
         wr_ok = tx_wr && !m_full;
         ld    = tx_tick && !m_busy && m_full;
         if (tx_tick && m_busy) begin
            if (m_t == m_ticks - 1) m_busy = 0;
            else m_t++;
         end
         if (ld) begin
            m_busy = 1; m_t = 0; m_byte = m_hold; m_full = 0;
            m_nd = 5 + int'(len_sel);
            m_pe = par_en;
            m_pv = ref_par(m_hold, m_nd, par_even);
            m_ticks = 16 * (1 + m_nd + int'(par_en)) +
                      (!stop_long ? 16 : (m_nd == 5 ? 24 : 32));
         end
         if (wr_ok) begin m_hold = tx_data; m_full = 1; end
      end
   end

   function automatic logic exp_sout();
      int idx;
      if (brk_force) return 1'b0;
      if (!m_busy) return 1'b1;
      idx = m_t / 16;
      if (idx == 0) return 1'b0;
      if (idx <= m_nd) return m_byte[idx-1];
      if (m_pe && idx == m_nd + 1) return m_pv;
      return 1'b1;
   endfunction

   // per-clock comparison, away from the edge
   always @(posedge clk) begin
      #5;
      if (!done) begin
         chk(req, "sout", 32'(sout), 32'(exp_sout()));
         chk(req, "tx_hold_empty", 32'(tx_hold_empty), 32'(!m_full));
         chk(req, "tx_shift_empty", 32'(tx_shift_empty), 32'(!m_busy));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic set_line(int len, bit pen, bit pev, bit sl);
      @(negedge clk);
      len_sel = 2'(len - 5); par_en = pen; par_even = pev; stop_long = sl;
   endtask

   task automatic tx_send(logic [7:0] d);
      @(negedge clk);
      while (m_full) @(negedge clk);
      tx_data = d; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic tx_drain();
      @(negedge clk);
      while (m_full || m_busy) @(negedge clk);
      repeat (8) @(negedge clk);
      chk(req, "shift empty after stop", 32'(tx_shift_empty), 32'd1);
   endtask

   task automatic rx_bit(bit v);
      sin = v;
      repeat (64) @(negedge clk);
   endtask

   task automatic rx_frame(logic [7:0] d, bit bad_par, bit stop_v, bit zero_par);
      int nd = 5 + int'(len_sel);
      @(negedge clk);
      rx_bit(1'b0);
      for (int i = 0; i < nd; i++) rx_bit(d[i]);
      if (par_en) rx_bit(zero_par ? 1'b0 : (ref_par(d, nd, par_even) ^ bad_par));
      rx_bit(stop_v);
   endtask

   task automatic rx_check(string tag, logic [7:0] d, bit rdy, bit ovr, bit pe, bit fe, bit bi);
      @(negedge clk);
      if (rdy) chk(tag, "rx_data", 32'(rx_data), 32'(d));
      chk(tag, "rx_rdy", 32'(rx_rdy), 32'(rdy));
      chk(tag, "ovr_err", 32'(ovr_err), 32'(ovr));
      chk(tag, "par_err", 32'(par_err), 32'(pe));
      chk(tag, "frm_err", 32'(frm_err), 32'(fe));
      chk(tag, "brk_det", 32'(brk_det), 32'(bi));
   endtask

   task automatic rx_read();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "sout idle", 32'(sout), 32'd1);
      chk("R1", "rx flags", 32'({rx_rdy, ovr_err, par_err, frm_err, brk_det}), 32'd0);

      // R2: plain 8-bit frame, two patterns
      req = "R2";
      set_line(8, 0, 0, 0); tx_send(8'hA5); tx_drain();
      tx_send(8'h3E); tx_drain();

      // R3: even and odd parity
      req = "R3";
      set_line(7, 1, 1, 0); tx_send(8'h35); tx_drain();
      set_line(6, 1, 0, 0); tx_send(8'h2B); tx_drain();

      // R4: long stop, 1.5 bits at 5 bits and 2 bits otherwise
      req = "R4";
      set_line(5, 0, 0, 1); tx_send(8'h15); tx_drain();
      set_line(8, 1, 1, 1); tx_send(8'h81); tx_drain();
      set_line(6, 0, 0, 1); tx_send(8'h0C); tx_drain();

      // R5: back-to-back, and a write into a full holding register is dropped
      req = "R5";
      set_line(8, 0, 0, 0);
      tx_send(8'h3C);
      tx_send(8'hC3);
      @(negedge clk); tx_data = 8'hFF; tx_wr = 1'b1;   // holding is full here
      @(negedge clk); tx_wr = 1'b0;
      tx_drain();

      // R6: break while idle and across a frame
      req = "R6";
      @(negedge clk); brk_force = 1'b1;
      repeat (200) @(negedge clk);
      brk_force = 1'b0;
      tx_send(8'h55);
      repeat (100) @(negedge clk); brk_force = 1'b1;
      repeat (150) @(negedge clk); brk_force = 1'b0;
      tx_drain();
      req = "R2";

      // R7: receive, 8 bits then 5 bits with unsent high bits zeroed
      set_line(8, 0, 0, 0);
      rx_frame(8'h5A, 0, 1, 0); rx_bit(1'b1);
      rx_check("R7", 8'h5A, 1, 0, 0, 0, 0);
      rx_read(); rx_check("R13", 8'h00, 0, 0, 0, 0, 0);
      set_line(5, 1, 1, 0);
      rx_frame(8'hF3, 0, 1, 0); rx_bit(1'b1);
      rx_check("R7", 8'h13, 1, 0, 0, 0, 0);
      rx_read();

      // R8: short low glitch is not a start
      @(negedge clk); sin = 1'b0;
      repeat (16) @(negedge clk); sin = 1'b1;
      repeat (200) @(negedge clk);
      rx_check("R8", 8'h00, 0, 0, 0, 0, 0);

      // R9: wrong parity bit with odd parity
      set_line(7, 1, 0, 0);
      rx_frame(8'h4D, 1, 1, 0); rx_bit(1'b1);
      rx_check("R9", 8'h4D, 1, 0, 1, 0, 0);
      rx_read();

      // R10: low stop bit with data present
      set_line(8, 0, 0, 0);
      rx_frame(8'h77, 0, 0, 0); rx_bit(1'b1);
      rx_check("R10", 8'h77, 1, 0, 0, 1, 0);
      rx_read();

      // R11: all-zero frame, line stays low, no second character until marking
      set_line(8, 1, 1, 0);
      rx_frame(8'h00, 0, 0, 1);
      rx_bit(1'b0);
      rx_check("R11", 8'h00, 1, 0, 0, 1, 1);
      rx_read();
      rx_bit(1'b0); rx_bit(1'b0); rx_bit(1'b0);
      rx_check("R11", 8'h00, 0, 0, 0, 0, 0);
      rx_bit(1'b1);
      rx_frame(8'h42, 0, 1, 0); rx_bit(1'b1);
      rx_check("R11", 8'h42, 1, 0, 0, 0, 0);
      rx_read();

      // R12: second character before the first is read
      set_line(8, 0, 0, 0);
      rx_frame(8'h11, 0, 1, 0); rx_bit(1'b1);
      rx_frame(8'h22, 0, 1, 0); rx_bit(1'b1);
      rx_check("R12", 8'h22, 1, 1, 0, 0, 0);
      rx_read();
      rx_check("R13", 8'h00, 0, 0, 0, 0, 0);

      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule